// File: doc/BRIEF.md
# Prescaled Up/Down Timer with Alternating Reload for PWM

The block is a 16-bit core counter clocked by a power-of-two prescaler, paired with two reload values that stand in for auxiliary timers. A 3-bit select picks the division ratio of the system clock. The counter steps up or down on each prescaled tick. The direction comes either from a control bit or from an external pin, chosen by a source-select input. Each time the counter wraps (past zero going down, or past all-ones going up) an output latch flips.

Each of the two reload channels can be enabled and set to act on one direction of that flip, either the latch going to 1 or the latch going to 0. When a wrap produces the selected transition, the counter is loaded with that channel's value on the same tick, in place of the wrapped count. If channel A acts on the rising flip with a high time and channel B on the falling flip with a low time, and the counter counts down, the latch becomes a free-running PWM waveform. No further writes are needed to sustain it.

A run input gates counting and holds the prescaler cleared while low. Software may also load the counter directly. That load overrides any step or reload in the same cycle. The prescaler base is a parameter, so the same module serves a divide-by-8 group (base 3) or a divide-by-4 group (base 2).

Top module: `pwm_reload_timer`

## Requirements
- R1: With prescaler base B (default 3) and select value s, the counter advances once every 2^(B+s) clock cycles while run is high. The first advance happens on the 2^(B+s)-th rising clock edge after run is seen high with a cleared prescaler.
- R2: When dir_src is 0 the direction is taken from dir_down, and when dir_src is 1 it is taken from ext_down. In both cases a value of 1 means count down and 0 means count up, and the unselected input has no effect.
- R3: Counting down from 0x0000 gives 0xFFFF, and counting up from 0xFFFF gives 0x0000. Each such wrap inverts tog, and tog changes at no other time.
- R4: On a wrap, an enabled reload channel whose rise bit equals the new latch value loads its value into the counter on that same tick. A rise bit of 1 acts on 0→1 and 0 acts on 1→0. A disabled or non-matching channel leaves the wrapped value in place.
- R5: When both channels match the same wrap, channel A's value is loaded.
- R6: With channel A on the rising flip holding H, channel B on the falling flip holding L, and counting down, tog stays high for exactly H+1 ticks and low for exactly L+1 ticks.
- R7: While run is low, count and tog hold their values and the prescaler is cleared, so after run returns high a full prescale period passes before the next advance.
- R8: A core write loads core_wdata into the counter on the next edge, overriding any step or reload on that edge. A wrap on that same tick still inverts tog.
- R9: After reset, count is 0x0000, tog is 0 and the prescaler is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | Counting enable; low holds the counter and clears the prescaler |
| psel | input | 3 | Prescale select, divider 2^(B+psel) |
| dir_src | input | 1 | Direction source: 0 control bit, 1 external pin |
| dir_down | input | 1 | Direction control bit, 1 = down |
| ext_down | input | 1 | External direction pin, 1 = down |
| core_wr | input | 1 | Direct load strobe for the counter |
| core_wdata | input | 16 | Value for the direct load |
| rl_a_en | input | 1 | Reload channel A enable |
| rl_a_rise | input | 1 | Channel A edge: 1 on latch rising, 0 on latch falling |
| rl_a_val | input | 16 | Channel A reload value |
| rl_b_en | input | 1 | Reload channel B enable |
| rl_b_rise | input | 1 | Channel B edge: 1 on latch rising, 0 on latch falling |
| rl_b_val | input | 16 | Channel B reload value |
| count | output | 16 | Current counter value |
| tog | output | 1 | Toggle latch output (PWM waveform) |

## Verification
The embedded properties check these rules on every cycle: the counter and latch stay frozen while stopped, the prescaler stays clear while stopped, the latch moves only on a prescaled tick, a direct load always lands, a non-wrapping tick moves the count by exactly one, and a matching reload with channel A's priority is applied. Only the bench scenarios can show the exact tick period for several select codes and where the first advance falls after a restart. They also show the selection between the direction sources, and that a reload-driven waveform keeps its high and low phase lengths over many periods.

// File: rtl/pwm_reload_timer.sv
module pwm_reload_timer #(
  parameter int WIDTH    = 16,
  parameter int SEL_W    = 3,
  parameter int PRE_BASE = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [SEL_W-1:0] psel,
  input  logic             dir_src,
  input  logic             dir_down,
  input  logic             ext_down,
  input  logic             core_wr,
  input  logic [WIDTH-1:0] core_wdata,
  input  logic             rl_a_en,
  input  logic             rl_a_rise,
  input  logic [WIDTH-1:0] rl_a_val,
  input  logic             rl_b_en,
  input  logic             rl_b_rise,
  input  logic [WIDTH-1:0] rl_b_val,
  output logic [WIDTH-1:0] count,
  output logic             tog
);

  localparam int PRE_W = PRE_BASE + (1 << SEL_W) - 1;
  localparam logic [WIDTH-1:0] TOP = '1;

  logic [PRE_W-1:0] pre_cnt;
  logic [PRE_W-1:0] pre_mask;
  logic [PRE_W:0]   div_full;
  logic             tick, down, wrap, a_hit, b_hit;
  logic [WIDTH-1:0] stepped;

  assign div_full = (PRE_W+1)'(1) << (PRE_BASE + 32'(psel));
  assign pre_mask = div_full[PRE_W-1:0] - PRE_W'(1);
  assign tick     = run && (pre_cnt == pre_mask);

  always_ff @(posedge clk) begin
    if (!rst_n || !run || tick) pre_cnt <= '0;
    else                        pre_cnt <= pre_cnt + PRE_W'(1);
  end

  assign down    = dir_src ? ext_down : dir_down;
  assign wrap    = tick && (down ? (count == '0) : (count == TOP));
  assign stepped = down ? count - WIDTH'(1) : count + WIDTH'(1);
  assign a_hit   = wrap && rl_a_en && (rl_a_rise == !tog);
  assign b_hit   = wrap && rl_b_en && (rl_b_rise == !tog);

  always_ff @(posedge clk) begin
    if (!rst_n)       count <= '0;
    else if (core_wr) count <= core_wdata;
    else if (a_hit)   count <= rl_a_val;
    else if (b_hit)   count <= rl_b_val;
    else if (tick)    count <= stepped;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    tog <= 1'b0;
    else if (wrap) tog <= !tog;
  end

  AST_STOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !core_wr) |=> ($stable(count) && $stable(tog))); // R7
  AST_PRE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (pre_cnt == '0)); // R7
  AST_TOG_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(tog)); // R3
  AST_WR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    core_wr |=> (count == $past(core_wdata))); // R8
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wrap && !core_wr) |=>
      (count == ($past(down) ? $past(count) - WIDTH'(1) : $past(count) + WIDTH'(1)))); // R2
  AST_RELOAD_A: assert property (@(posedge clk) disable iff (!rst_n)
    (a_hit && !core_wr) |=> (count == $past(rl_a_val))); // R5
  AST_RELOAD_B: assert property (@(posedge clk) disable iff (!rst_n)
    (b_hit && !a_hit && !core_wr) |=> (count == $past(rl_b_val))); // R4

endmodule

// File: tb/pwm_reload_timer_test.sv
module pwm_reload_timer_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 6;
  // {psel[46:44], dir_src[43], dir_down[42], ext_down[41], start[40:25], ticks[24:17], expect[16:1], wraps_odd[0]}
  localparam logic [46:0] VEC [NV] = '{
    {3'd0, 1'b0, 1'b0, 1'b1, 16'h0000, 8'd5, 16'h0005, 1'b0},
    {3'd0, 1'b0, 1'b1, 1'b0, 16'h0003, 8'd5, 16'hFFFE, 1'b1},
    {3'd1, 1'b0, 1'b0, 1'b0, 16'hFFFE, 8'd3, 16'h0001, 1'b1},
    {3'd2, 1'b0, 1'b1, 1'b1, 16'h0100, 8'd4, 16'h00FC, 1'b0},
    {3'd0, 1'b1, 1'b0, 1'b1, 16'h0010, 8'd2, 16'h000E, 1'b0},
    {3'd7, 1'b1, 1'b1, 1'b0, 16'h1234, 8'd2, 16'h1236, 1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0, run = 1'b0;
  logic [2:0] psel = '0;
  logic dir_src = 0, dir_down = 0, ext_down = 0, core_wr = 0;
  logic [15:0] core_wdata = '0;
  logic rl_a_en = 0, rl_a_rise = 0, rl_b_en = 0, rl_b_rise = 0;
  logic [15:0] rl_a_val = '0, rl_b_val = '0;
  logic [15:0] count;
  logic tog;
  int checks = 0, failures = 0;
  bit done = 0;

  pwm_reload_timer uut (
    .clk(clk), .rst_n(rst_n), .run(run), .psel(psel), .dir_src(dir_src),
    .dir_down(dir_down), .ext_down(ext_down), .core_wr(core_wr),
    .core_wdata(core_wdata), .rl_a_en(rl_a_en), .rl_a_rise(rl_a_rise),
    .rl_a_val(rl_a_val), .rl_b_en(rl_b_en), .rl_b_rise(rl_b_rise),
    .rl_b_val(rl_b_val), .count(count), .tog(tog));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load(input logic [15:0] v);
    run = 0; core_wr = 1; core_wdata = v;
    step(1);
    core_wr = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    logic tog_exp;
    logic t0;
    @(negedge clk);
    step(3);
    rst_n = 1;
    step(1);
    check(count == 16'h0000, "R9 count", 32'(count), 0);
    check(tog == 1'b0, "R9 tog", 32'(tog), 0);
    tog_exp = 1'b0;

    // vector table: R1 R2 R3
    for (int i = 0; i < NV; i++) begin
      logic [46:0] v;
      int cyc;
      v = VEC[i];
      load(v[40:25]);
      psel = v[46:44]; dir_src = v[43]; dir_down = v[42]; ext_down = v[41];
      run = 1;
      cyc = int'(v[24:17]) << (3 + int'(v[46:44]));
      step(cyc);
      check(count == v[16:1], "R1/R2/R3 vector count", 32'(count), 32'(v[16:1]));
      tog_exp = tog_exp ^ v[0];
      check(tog == tog_exp, "R3 vector tog", 32'(tog), 32'(tog_exp));
    end

    // R1 boundary: no advance at edge 7, advance at edge 8
    psel = 0; dir_src = 0; dir_down = 0;
    load(16'h0040);
    run = 1;
    step(7);
    check(count == 16'h0040, "R1 before period", 32'(count), 32'h40);
    step(1);
    check(count == 16'h0041, "R1 at period", 32'(count), 32'h41);

    // R7: freeze and prescaler clear
    step(3);
    run = 0;
    step(50);
    check(count == 16'h0041, "R7 frozen count", 32'(count), 32'h41);
    check(tog == tog_exp, "R7 frozen tog", 32'(tog), 32'(tog_exp));
    run = 1;
    step(7);
    check(count == 16'h0041, "R7 restart full period", 32'(count), 32'h41);
    step(1);
    check(count == 16'h0042, "R7 restart advance", 32'(count), 32'h42);

    // R8: write on a reloading wrap tick
    dir_down = 1;
    load(16'h0000);
    t0 = tog;
    rl_a_en = 1; rl_a_rise = !t0; rl_a_val = 16'h0033;
    run = 1;
    step(7);
    check(count == 16'h0000, "R8 pre-tick", 32'(count), 0);
    core_wr = 1; core_wdata = 16'h0AAA;
    step(1);
    core_wr = 0;
    check(count == 16'h0AAA, "R8 write wins", 32'(count), 32'hAAA);
    check(tog == !t0, "R8 tog still flips", 32'(tog), 32'(!t0));

    // R4: channel A reload
    load(16'h0000);
    rl_a_rise = t0;
    run = 1;
    step(8);
    check(count == 16'h0033, "R4 reload A", 32'(count), 32'h33);
    check(tog == t0, "R4 tog", 32'(tog), 32'(t0));

    // R5: both match, A wins
    load(16'h0000);
    rl_a_rise = !t0; rl_a_val = 16'h0055;
    rl_b_en = 1; rl_b_rise = !t0; rl_b_val = 16'h0066;
    run = 1;
    step(8);
    check(count == 16'h0055, "R5 A priority", 32'(count), 32'h55);

    // R4: B alone matches
    load(16'h0000);
    rl_a_en = 0; rl_b_rise = t0;
    run = 1;
    step(8);
    check(count == 16'h0066, "R4 reload B", 32'(count), 32'h66);

    // R4: non-matching edge gives plain wrap
    load(16'h0000);
    rl_b_rise = t0;
    run = 1;
    step(8);
    check(count == 16'hFFFF, "R4 edge mismatch", 32'(count), 32'hFFFF);

    // R6: autonomous PWM, H=2 L=4
    load(16'h0000);
    rl_a_en = 1; rl_a_rise = 1; rl_a_val = 16'd2;
    rl_b_en = 1; rl_b_rise = 0; rl_b_val = 16'd4;
    dir_down = 1; run = 1;
    begin
      logic prev;
      int since;
      bit seen;
      prev = tog; since = 0; seen = 0;
      for (int k = 0; k < 48; k++) begin
        step(8);
        since++;
        if (tog != prev) begin
          check(count == (tog ? 16'd2 : 16'd4), "R6 reload value", 32'(count), tog ? 32'd2 : 32'd4);
          if (seen)
            check(since == (tog ? 5 : 3), "R6 phase length", 32'(since), tog ? 32'd5 : 32'd3);
          seen = 1; since = 0; prev = tog;
        end
      end
    end
    finish_run();
  end
endmodule